// File: doc/BRIEF.md
# LED Colour Strobe Decoder with Break-Before-Make Sequencing

This block turns a 2-bit colour-select code into gate commands for six LED path switches. A configuration bit chooses between two switch maps: one for an LED package whose three anodes are tied together, and one for a package with two cathode-side legs and one anode-side leg. For the chosen colour, the block also forwards one of three 10-bit current codes to the LED current DAC. It flags transient current limiting for that colour when limiting is enabled for it.

A change in the switch pattern is never applied in one step. Switches that must open are opened at once. Switches that stay closed remain closed. Switches that must newly close are held off for a programmable dead time of (2 + code) units of 111 ns. One unit is a parameterised number of clock cycles. If the select changes again before the dead time has run out, the sequence starts again from the switch state reached so far, toward the newest target. With the LED stage disabled, the target is all-open.

Top module: `led_strobe_seq`

## Requirements
- R1: With `map_cc`=0 and `enable`=1, the settled `sw_gate` (bit 0 = SW1 … bit 5 = SW6) is 0x07 for select 0, and 0x0F, 0x17 and 0x27 for selects 1, 2 and 3.
- R2: With `map_cc`=1 and `enable`=1, the settled `sw_gate` is 0x00 for select 0, and 0x21, 0x1C and 0x1A for selects 1, 2 and 3.
- R3: One clock after the select is sampled, `dac_code` shows `idac_sw4`, `idac_sw5` or `idac_sw6` for colour 1, 2 or 3. It is 0 for colour 0 or while disabled.
- R4: At the clock edge that samples a new target, every switch that is absent from the target opens. No switch closes at that edge.
- R5: A switch that is closed before the change and is also in the new target stays closed through the whole dead time.
- R6: Newly closed switches close exactly (2 + `dead_code`) × UNIT_CYCLES clock edges after the edge that sampled the change. Until then, `sw_gate` holds the partly opened pattern.
- R7: One clock after sampling, `lim_flag[i]` equals `lim_en[i]` when colour i+1 is active and is 0 otherwise, so at most one bit is set. `lim_code` is the registered `lim_code_in`.
- R8: While `enable` is 0, `sw_gate` is 0 one edge later, and changes of `led_sel` and `map_cc` do not close any switch.
- R9: A target change that is sampled during a dead time, including at the edge where the dead time would expire, opens the switches the new target lacks. It then restarts the full dead time toward the newest target, and the earlier target's closures are never applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | LED stage enable; 0 forces all switches open |
| map_cc | input | 1 | Switch map: 0 = shared anode, 1 = cathode-cathode-anode |
| led_sel | input | 2 | Colour select (0 = none, 1..3 = colour) |
| idac_sw4 | input | 10 | Current code for colour 1 |
| idac_sw5 | input | 10 | Current code for colour 2 |
| idac_sw6 | input | 10 | Current code for colour 3 |
| dead_code | input | 8 | Dead-time code, sampled when a sequence starts |
| lim_code_in | input | 3 | Transient current-limit level |
| lim_en | input | 3 | Per-colour transient-limit enables (bit 0 = colour 1) |
| sw_gate | output | 6 | Switch gate commands, bit 0 = SW1 |
| dac_code | output | 10 | Current code forwarded to the DAC |
| lim_flag | output | 3 | Transient-limit active flag per colour |
| lim_code | output | 3 | Registered transient-limit level |

## Verification
Two functions of the block can fall in the same clock edge: the dead-time counter expiring and a fresh target change arriving. The bench provokes this by waiting exactly one edge less than the dead time after a change, then presenting a new select, so that the new select is sampled on the expiry edge. It judges the result by requiring that the old target's closures never appear. The switches must instead drop to the intersection with the newest target and close to it only after a full new dead time. A second race is also checked: a disable arriving during a dead time must leave every switch open.

// File: rtl/led_strobe_pkg.sv
package led_strobe_pkg;

  localparam int unsigned N_SW   = 6;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned IDAC_W = 10;
  localparam int unsigned DT_W   = 8;
  localparam int unsigned LIM_W  = 3;
  localparam int unsigned N_COL  = 3;
  localparam int unsigned DT_BASE_UNITS = 2;

  // Switch pattern for a map and colour; bit 0 drives SW1.
  function automatic logic [N_SW-1:0] sw_pattern(input logic map_cc,
                                                 input logic [SEL_W-1:0] col);
    logic [N_SW-1:0] p;
    if (!map_cc) begin
      p = 6'b000111;
      if (col != 2'd0) p[3 + int'(col) - 1] = 1'b1;
    end else begin
      unique case (col)
        2'd1:    p = 6'b100001;
        2'd2:    p = 6'b011100;
        2'd3:    p = 6'b011010;
        default: p = 6'b000000;
      endcase
    end
    return p;
  endfunction

  // Dead time in clock cycles: (base + code) units of unit_cyc cycles.
  function automatic int unsigned bbm_cycles(input logic [DT_W-1:0] code,
                                             input int unsigned unit_cyc);
    return (DT_BASE_UNITS + 32'(code)) * unit_cyc;
  endfunction

endpackage

// File: rtl/led_strobe_map.sv
module led_strobe_map
  import led_strobe_pkg::*;
(
  input  logic             enable,
  input  logic             map_cc,
  input  logic [SEL_W-1:0] led_sel,
  output logic [SEL_W-1:0] col_o,
  output logic [N_SW-1:0]  pat_o
);
  // Disabled stage behaves as colour 0 with every switch open.
  always_comb begin
    if (enable) begin
      col_o = led_sel;
      pat_o = sw_pattern(map_cc, led_sel);
    end else begin
      col_o = '0;
      pat_o = '0;
    end
  end
endmodule

// File: rtl/led_bbm_timer.sv
module led_bbm_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cancel,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign done = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (cancel) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/led_drive_select.sv
module led_drive_select
  import led_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  col,
  input  logic [IDAC_W-1:0] idac_sw4,
  input  logic [IDAC_W-1:0] idac_sw5,
  input  logic [IDAC_W-1:0] idac_sw6,
  input  logic [N_COL-1:0]  lim_en,
  input  logic [LIM_W-1:0]  lim_code_in,
  output logic [IDAC_W-1:0] dac_o,
  output logic [N_COL-1:0]  lim_flag_o,
  output logic [LIM_W-1:0]  lim_code_o
);
  logic [IDAC_W-1:0] dac_d;
  logic [N_COL-1:0]  col_hot;

  always_comb begin
    unique case (col)
      2'd1:    dac_d = idac_sw4;
      2'd2:    dac_d = idac_sw5;
      2'd3:    dac_d = idac_sw6;
      default: dac_d = '0;
    endcase
  end

  for (genvar i = 0; i < N_COL; i++) begin : g_col
    assign col_hot[i] = (col == SEL_W'(i + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_o      <= '0;
      lim_flag_o <= '0;
      lim_code_o <= '0;
    end else begin
      dac_o      <= dac_d;
      lim_flag_o <= lim_en & col_hot;
      lim_code_o <= lim_code_in;
    end
  end
endmodule

// File: rtl/led_strobe_seq.sv
module led_strobe_seq
  import led_strobe_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              map_cc,
  input  logic [1:0]        led_sel,
  input  logic [9:0]        idac_sw4,
  input  logic [9:0]        idac_sw5,
  input  logic [9:0]        idac_sw6,
  input  logic [7:0]        dead_code,
  input  logic [2:0]        lim_code_in,
  input  logic [2:0]        lim_en,
  output logic [5:0]        sw_gate,
  output logic [9:0]        dac_code,
  output logic [2:0]        lim_flag,
  output logic [2:0]        lim_code
);
  localparam int unsigned MAX_DEAD = (DT_BASE_UNITS + (1 << DT_W) - 1) * UNIT_CYCLES;
  localparam int unsigned CNT_W    = $clog2(MAX_DEAD + 1);

  logic [SEL_W-1:0] col_now, col_q;
  logic [N_SW-1:0]  pat_now, pat_q, gate_q;
  logic             chg, need_close, tmr_load, tmr_cancel, tmr_done;
  logic [CNT_W-1:0] dead_load;

  led_strobe_map u_map (
    .enable  (enable),
    .map_cc  (map_cc),
    .led_sel (led_sel),
    .col_o   (col_now),
    .pat_o   (pat_now)
  );

  // Events brought out by name for the checker.
  assign chg        = (col_now != col_q) || (pat_now != pat_q);
  assign need_close = |(pat_now & ~gate_q);
  assign tmr_load   = chg && need_close;
  assign tmr_cancel = chg && !need_close;
  assign dead_load  = CNT_W'(bbm_cycles(dead_code, UNIT_CYCLES) - 32'd1);

  led_bbm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .cancel   (tmr_cancel),
    .load_val (dead_load),
    .done     (tmr_done)
  );

  // A change opens at once; closing waits for the timer. A change wins
  // over an expiring timer and restarts the sequence.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      pat_q  <= '0;
      col_q  <= '0;
    end else if (chg) begin
      gate_q <= gate_q & pat_now;
      pat_q  <= pat_now;
      col_q  <= col_now;
    end else if (tmr_done) begin
      gate_q <= pat_q;
    end
  end

  assign sw_gate = gate_q;

  led_drive_select u_drv (
    .clk         (clk),
    .rst_n       (rst_n),
    .col         (col_now),
    .idac_sw4    (idac_sw4),
    .idac_sw5    (idac_sw5),
    .idac_sw6    (idac_sw6),
    .lim_en      (lim_en),
    .lim_code_in (lim_code_in),
    .dac_o       (dac_code),
    .lim_flag_o  (lim_flag),
    .lim_code_o  (lim_code)
  );
endmodule

// File: rtl/led_strobe_seq_chk.sv
module led_strobe_seq_chk
  import led_strobe_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [N_SW-1:0]  gate,
  input logic [N_SW-1:0]  tgt,
  input logic [SEL_W-1:0] col_q,
  input logic             chg,
  input logic             load,
  input logic             cancel,
  input logic             done,
  input logic [DT_W-1:0]  dead_code,
  input logic [IDAC_W-1:0] dac,
  input logic [N_COL-1:0] lim_flag
);
  logic        armed;
  logic [31:0] seen, expect_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      seen       <= '0;
      expect_cyc <= '0;
    end else if (load) begin
      armed      <= 1'b1;
      seen       <= 32'd1;
      expect_cyc <= bbm_cycles(dead_code, UNIT_CYCLES);
    end else if (cancel || done) begin
      armed <= 1'b0;
    end else if (armed) begin
      seen <= seen + 32'd1;
    end
  end

  assert_dac_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q == '0) |-> (dac == '0));

  assert_open_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ((gate & ~$past(gate)) == '0));

  assert_keep_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> ((gate & $past(gate & tgt)) == $past(gate & tgt)));

  assert_dead_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && armed) |-> (seen == expect_cyc));

  assert_lim_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lim_flag));

  assert_off_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (gate == '0));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done);
endmodule

bind led_strobe_seq led_strobe_seq_chk #(.UNIT_CYCLES(UNIT_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .gate      (sw_gate),
  .tgt       (pat_now),
  .col_q     (col_q),
  .chg       (chg),
  .load      (tmr_load),
  .cancel    (tmr_cancel),
  .done      (tmr_done),
  .dead_code (dead_code),
  .dac       (dac_code),
  .lim_flag  (lim_flag)
);

// File: tb/led_strobe_seq_test.sv
module led_strobe_seq_test;
  localparam int UNIT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, map_cc = 1'b0;
  logic [1:0] led_sel = 2'd0;
  logic [9:0] idac4 = 10'h000, idac5 = 10'h000, idac6 = 10'h000;
  logic [7:0] dead_code = 8'd0;
  logic [2:0] lim_code_in = 3'd0, lim_en = 3'd0;
  logic [5:0] sw_gate;
  logic [9:0] dac_code;
  logic [2:0] lim_flag, lim_code;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [5:0] cur = 6'd0, cur_tgt = 6'd0;
  logic [1:0] cur_col = 2'd0;

  always #4 clk = ~clk;

  led_strobe_seq #(.UNIT_CYCLES(UNIT)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .map_cc(map_cc),
    .led_sel(led_sel), .idac_sw4(idac4), .idac_sw5(idac5), .idac_sw6(idac6),
    .dead_code(dead_code), .lim_code_in(lim_code_in), .lim_en(lim_en),
    .sw_gate(sw_gate), .dac_code(dac_code), .lim_flag(lim_flag),
    .lim_code(lim_code)
  );

  // Expected patterns written as closed-switch lists (SW numbers 1..6).
  function automatic logic [5:0] sw_set(input int a, input int b, input int c);
    logic [5:0] r = 6'd0;
    if (a > 0) r[a-1] = 1'b1;
    if (b > 0) r[b-1] = 1'b1;
    if (c > 0) r[c-1] = 1'b1;
    return r;
  endfunction

  function automatic logic [5:0] want_pat(input bit en, input bit mp, input logic [1:0] s);
    if (!en) return 6'd0;
    if (!mp) return sw_set(1, 2, 3) | ((s == 2'd0) ? 6'd0 : sw_set(3 + int'(s), 0, 0));
    case (s)
      2'd1:    return sw_set(6, 1, 0);
      2'd2:    return sw_set(5, 4, 3);
      2'd3:    return sw_set(5, 4, 2);
      default: return 6'd0;
    endcase
  endfunction

  function automatic int want_dead(input logic [7:0] dc);
    int ns = 222 + 111 * int'(dc);
    return (ns / 111) * UNIT;
  endfunction

  function automatic logic [9:0] want_dac(input logic [1:0] c);
    case (c)
      2'd1:    return idac4;
      2'd2:    return idac5;
      2'd3:    return idac6;
      default: return 10'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Applies a target at a negedge. hold > 0 stops after hold extra
  // negedges, leaving the dead time running.
  task automatic step(input bit en, input bit mp, input logic [1:0] s,
                      input logic [7:0] dc, input int hold);
    logic [5:0] tgt;
    logic [1:0] col;
    int n;
    bit bad;
    enable = en; map_cc = mp; led_sel = s; dead_code = dc;
    tgt = want_pat(en, mp, s);
    col = en ? s : 2'd0;
    @(negedge clk);
    chk("R3 dac code", 32'(dac_code), 32'(want_dac(col)));
    chk("R7 limit flag", 32'(lim_flag), (col == 2'd0) ? 32'd0 : 32'(lim_en[int'(col)-1]) << (int'(col)-1));
    chk("R7 limit code", 32'(lim_code), 32'(lim_code_in));
    if (tgt == cur_tgt && col == cur_col) begin
      chk("R8 unchanged target ignored", 32'(sw_gate), 32'(cur));
      return;
    end
    cur = cur & tgt;
    cur_tgt = tgt; cur_col = col;
    chk("R4/R5 open first, keep common", 32'(sw_gate), 32'(cur));
    if (!en) chk("R8 disable opens all", 32'(sw_gate), 32'd0);
    if ((tgt & ~cur) == 6'd0) return;
    n = 0; bad = 0;
    while (1) begin
      if (hold > 0 && n == hold) break;
      @(negedge clk); n++;
      if (sw_gate == tgt) break;
      if (sw_gate != cur) bad = 1;
      if (n > 3000) break;
    end
    chk("R6 hold partial pattern during dead time", 32'(bad), 32'd0);
    if (hold > 0 && n == hold) begin
      chk("R9 no early close", 32'(sw_gate), 32'(cur));
      return;
    end
    chk("R6 dead time length", 32'(n), 32'(want_dead(dc)));
    chk(mp ? "R2 settled map1 pattern" : "R1 settled map0 pattern", 32'(sw_gate), 32'(tgt));
    cur = tgt;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1eed_5a17));
    idac4 = 10'h155; idac5 = 10'h2aa; idac6 = 10'h3ff;
    lim_en = 3'b101; lim_code_in = 3'd5;
    repeat (3) @(negedge clk);
    chk("R8 reset gates open", 32'(sw_gate), 32'd0);
    chk("R3 reset dac zero", 32'(dac_code), 32'd0);
    chk("R7 reset flags clear", 32'(lim_flag), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: shared-anode map, each colour, short and long dead times
    step(1, 0, 2'd0, 8'd0, 0);
    step(1, 0, 2'd1, 8'd1, 0);
    step(1, 0, 2'd2, 8'd255, 0);
    step(1, 0, 2'd3, 8'd7, 0);
    step(1, 0, 2'd0, 8'd3, 0);
    // R2: other map, including the all-open select
    step(1, 1, 2'd1, 8'd2, 0);
    step(1, 1, 2'd2, 8'd0, 0);
    step(1, 1, 2'd3, 8'd4, 0);  // R5: SW4/SW5 stay closed
    step(1, 1, 2'd0, 8'd4, 0);
    step(1, 1, 2'd2, 8'd9, 0);
    // R9: restart mid dead time, then at the exact expiry edge
    step(1, 0, 2'd1, 8'd10, 5);
    step(1, 0, 2'd2, 8'd10, 0);
    step(1, 0, 2'd3, 8'd6, want_dead(8'd6) - 1);
    step(1, 1, 2'd3, 8'd2, 0);
    // R8: disable during a dead time, select changes while disabled
    step(1, 0, 2'd1, 8'd20, 4);
    step(0, 0, 2'd1, 8'd20, 0);
    step(0, 1, 2'd2, 8'd0, 0);
    repeat (10) @(negedge clk);
    chk("R8 stays open while disabled", 32'(sw_gate), 32'd0);
    step(1, 0, 2'd2, 8'd0, 0);

    for (int i = 0; i < 60; i++) begin
      idac4 = 10'($urandom); idac5 = 10'($urandom); idac6 = 10'($urandom);
      lim_en = 3'($urandom); lim_code_in = 3'($urandom);
      step(($urandom % 8) != 0, 1'($urandom), 2'($urandom),
           8'($urandom % 48), (($urandom % 4) == 0) ? 1 + int'($urandom % 6) : 0);
    end
    step(1, 0, 2'd3, 8'd0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule